// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Sequencer

This block runs single transfers on a local bus whose sixteen low address bits share pins with the data. A 20-bit address is shown on the shared lines and the upper address lines in the first clock, where an address strobe lets external latches capture it. The same lines then carry the data. A requester presents a transfer: a 3-bit status code that also gives the transfer type, an address, a byte-or-word size, write data, an initiator code and a lock flag. The sequencer takes it on `reqAccept`.

Each cycle has four base phases: address, strobe, sample and finish. Wait states repeat the sample phase until a ready input is seen. Three inputs can end the wait: a synchronous ready, an asynchronous ready that has already been synchronized, and an auto-ready from the chip-select logic. The block also drives a byte-lane code, an initiator flag on the top address line, and transceiver enable and direction. An external master can take the bus through a hold handshake, which a locked sequence of cycles defers.

Top module: `busCycleUnit`

## Requirements
- R1: A bus cycle takes at least four clocks: address (ale=1), strobe, sample and finish. After a cycle is accepted, `ale` is high in the next clock only.
- R2: In the sample phase the cycle waits, one clock per wait state, until `srdy` or `ardySync` is high at a rising edge. It then moves to finish.
- R3: If `csAutoRdy` is high at the end of a sample clock, the cycle ends even when both external readies are low.
- R4: `statusN` carries the request code from address through sample: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 instruction fetch, 101 memory read, 110 memory write. It reads 111 (passive) in finish, in idle, in hold and after reset.
- R5: During a cycle, the pair {AD bit 0 in the address phase, `bheN`} is 00 for a word, 01 for an even byte and 10 for an odd byte. It is 11 for any refresh cycle (`reqInit`=2). `bheN` is 1 outside cycles.
- R6: In the address phase `addrHi` shows address bits 19:16. From strobe through finish, `addrHi[3]` is 0 for the CPU (`reqInit`=0) and 1 for any other initiator, and `addrHi[2:0]` are 0.
- R7: In the address phase `adOut` shows the address and `adOe`=1. From strobe through finish, write cycles (codes 010, 110) drive the write data, and all other cycles release the lines (`adOe`=0).
- R8: For read codes (001, 100, 101), `rdN` is low in the strobe and sample clocks only. For write codes, `wrN` is low in those same clocks. Both strobes are high at all other times.
- R9: `denN` is low from strobe through finish, except for codes 011 and 111. `dtR` is 1 for writes and 0 for other codes for the whole cycle, and 1 when no cycle is running.
- R10: If `holdReq` is high when the bus is idle or in finish, and no lock is pending, the bus enters hold on the next clock. In hold, `hlda`=1 and `adOe`, `addrHiOe` and `ctrlOe` are 0. It returns to idle in the clock after `holdReq` falls.
- R11: If the cycle in progress was accepted with `reqLock`=1, a request present in its finish clock starts the next cycle even while `holdReq` is high.
- R12: `reqAccept` is high exactly when the bus is idle or in finish, `reqValid` is high and no hold is being granted. A request accepted in finish starts its address phase with no idle clock in between.
- R13: Codes 011 and 111 finish after one sample clock, whatever the ready inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Transfer request present |
| reqKind | input | 3 | Status code / transfer type |
| reqAddr | input | 20 | Transfer address |
| reqByte | input | 1 | 1 = byte transfer, 0 = word |
| reqWrData | input | 16 | Write data |
| reqInit | input | 2 | Initiator: 0 CPU, 1 DMA, 2 refresh |
| reqLock | input | 1 | Keep bus after this cycle |
| reqAccept | output | 1 | Request taken this clock |
| srdy | input | 1 | Synchronous ready |
| ardySync | input | 1 | Asynchronous ready, already synchronized |
| csAutoRdy | input | 1 | Chip-select supplies ready |
| holdReq | input | 1 | External master requests bus |
| adOut | output | 16 | Address/data lines |
| adOe | output | 1 | Drive enable for adOut |
| addrHi | output | 4 | Address 19:16 / initiator flag |
| addrHiOe | output | 1 | Drive enable for addrHi |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| statusN | output | 3 | Bus status code |
| bheN | output | 1 | High byte enable, active low |
| denN | output | 1 | Transceiver enable, active low |
| dtR | output | 1 | Transceiver direction, 1 = transmit |
| ctrlOe | output | 1 | Drive enable for control and status |
| hlda | output | 1 | Hold acknowledge |

## Verification
A wrong phase register shows at once, in the same clock, as a mismatch on `ale`, the strobes or `statusN`, because every output decodes the current phase. A miscounted wait shows as a strobe that rises one clock early or late. A stale request register corrupts the byte-lane pair or the data-phase flag in the next address or data phase. A lost lock or hold decision shows within one clock on `hlda` or `reqAccept`. The reference model checks every output on every clock, across epochs that vary how often ready arrives, which ready source fires, and how hard hold is requested.

// File: rtl/busc_pkg.sv
package busc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_STROBE = 3'd2,
    PH_SAMPLE = 3'd3,
    PH_FINISH = 3'd4,
    PH_HOLD   = 3'd5
  } phase_e;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic loadReq;
    logic showAddr;
    logic showData;
    logic statusLive;
    logic cycleLive;
    logic floatBus;
  } dpCtl_t;

  // Decoded request attributes from datapath to sequencer
  typedef struct packed {
    logic isRead;
    logic isWrite;
    logic quiet;
  } reqInfo_t;

  localparam logic [2:0] ST_PASSIVE = 3'b111;
  localparam logic [1:0] INIT_CPU   = 2'd0;
  localparam logic [1:0] INIT_RFSH  = 2'd2;
endpackage

// File: rtl/busDatapath.sv
module busDatapath
  import busc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqByte,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [1:0]        reqInit,
  output reqInfo_t          info,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic              addrHiOe,
  output logic [2:0]        statusN,
  output logic              bheN,
  output logic              dtR
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [2:0]        kindR;
  logic [ADDR_W-1:0] addrR;
  logic              byteR;
  logic [DATA_W-1:0] dataR;
  logic [1:0]        initR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindR <= ST_PASSIVE;
      addrR <= '0;
      byteR <= 1'b0;
      dataR <= '0;
      initR <= INIT_CPU;
    end else if (ctl.loadReq) begin
      kindR <= reqKind;
      addrR <= reqAddr;
      byteR <= reqByte;
      dataR <= reqWrData;
      initR <= reqInit;
    end
  end

  logic isRefresh, notCpu, laneA0, laneBheN;

  always_comb begin
    info.isRead  = (kindR == 3'b001) || (kindR == 3'b100) || (kindR == 3'b101);
    info.isWrite = (kindR == 3'b010) || (kindR == 3'b110);
    info.quiet   = (kindR[1:0] == 2'b11);
    isRefresh    = (initR == INIT_RFSH);
    notCpu       = (initR != INIT_CPU);
    laneA0       = isRefresh | addrR[0];
    laneBheN     = isRefresh | (byteR & ~addrR[0]);
  end

  always_comb begin
    adOut  = '0;
    addrHi = '0;
    if (ctl.showAddr) begin
      adOut  = {addrR[DATA_W-1:1], laneA0};
      addrHi = addrR[ADDR_W-1:DATA_W];
    end else if (ctl.showData) begin
      adOut  = dataR;
      addrHi = {notCpu, {(HI_W-1){1'b0}}};
    end
    adOe     = ctl.showAddr | (ctl.showData & info.isWrite);
    addrHiOe = ~ctl.floatBus;
    statusN  = ctl.statusLive ? kindR : ST_PASSIVE;
    bheN     = ctl.cycleLive ? laneBheN : 1'b1;
    dtR      = ctl.cycleLive ? info.isWrite : 1'b1;
  end
endmodule

// File: rtl/busSequencer.sv
module busSequencer
  import busc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqLock,
  input  logic     srdy,
  input  logic     ardySync,
  input  logic     csAutoRdy,
  input  logic     holdReq,
  input  reqInfo_t info,
  output dpCtl_t   ctl,
  output logic     reqAccept,
  output logic     ale,
  output logic     rdN,
  output logic     wrN,
  output logic     denN,
  output logic     ctrlOe,
  output logic     hlda
);
  phase_e ph, phNext;
  logic   lockHeld, lockNext;
  logic   holdBlock, canStart, rdyHit, strobePh, dataPh;

  always_comb begin
    holdBlock = holdReq & ~lockHeld;
    canStart  = (ph == PH_IDLE) || (ph == PH_FINISH);
    reqAccept = canStart & reqValid & ~holdBlock;
    rdyHit    = srdy | ardySync | csAutoRdy | info.quiet;
    strobePh  = (ph == PH_STROBE) || (ph == PH_SAMPLE);
    dataPh    = strobePh || (ph == PH_FINISH);
  end

  always_comb begin
    phNext   = ph;
    lockNext = lockHeld;
    unique case (ph)
      PH_IDLE: begin
        if (holdBlock) phNext = PH_HOLD;
        else if (reqValid) begin
          phNext   = PH_ADDR;
          lockNext = reqLock;
        end else lockNext = 1'b0;
      end
      PH_ADDR:   phNext = PH_STROBE;
      PH_STROBE: phNext = PH_SAMPLE;
      PH_SAMPLE: if (rdyHit) phNext = PH_FINISH;
      PH_FINISH: begin
        if (holdBlock) phNext = PH_HOLD;
        else if (reqValid) begin
          phNext   = PH_ADDR;
          lockNext = reqLock;
        end else phNext = PH_IDLE;
      end
      PH_HOLD: begin
        lockNext = 1'b0;
        if (!holdReq) phNext = PH_IDLE;
      end
      default: phNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ph       <= PH_IDLE;
      lockHeld <= 1'b0;
    end else begin
      ph       <= phNext;
      lockHeld <= lockNext;
    end
  end

  always_comb begin
    ctl.loadReq    = reqAccept;
    ctl.showAddr   = (ph == PH_ADDR);
    ctl.showData   = dataPh;
    ctl.statusLive = (ph == PH_ADDR) || strobePh;
    ctl.cycleLive  = (ph == PH_ADDR) || dataPh;
    ctl.floatBus   = (ph == PH_HOLD);
    ale    = (ph == PH_ADDR);
    rdN    = ~(strobePh & info.isRead);
    wrN    = ~(strobePh & info.isWrite);
    denN   = ~(dataPh & ~info.quiet);
    ctrlOe = (ph != PH_HOLD);
    hlda   = (ph == PH_HOLD);
  end
endmodule

// File: rtl/busCycleUnit.sv
module busCycleUnit
  import busc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqByte,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [1:0]        reqInit,
  input  logic              reqLock,
  output logic              reqAccept,
  input  logic              srdy,
  input  logic              ardySync,
  input  logic              csAutoRdy,
  input  logic              holdReq,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic              addrHiOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic [2:0]        statusN,
  output logic              bheN,
  output logic              denN,
  output logic              dtR,
  output logic              ctrlOe,
  output logic              hlda
);
  dpCtl_t   ctl;
  reqInfo_t info;

  busSequencer u_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLock(reqLock),
    .srdy(srdy), .ardySync(ardySync), .csAutoRdy(csAutoRdy), .holdReq(holdReq),
    .info(info), .ctl(ctl), .reqAccept(reqAccept), .ale(ale), .rdN(rdN),
    .wrN(wrN), .denN(denN), .ctrlOe(ctrlOe), .hlda(hlda)
  );

  busDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqByte(reqByte), .reqWrData(reqWrData), .reqInit(reqInit), .info(info),
    .adOut(adOut), .adOe(adOe), .addrHi(addrHi), .addrHiOe(addrHiOe),
    .statusN(statusN), .bheN(bheN), .dtR(dtR)
  );
endmodule

// File: rtl/busCycleUnit_chk.sv
module busCycleUnit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqAccept,
  input logic       srdy,
  input logic       ardySync,
  input logic       csAutoRdy,
  input logic       adOe,
  input logic       addrHiOe,
  input logic       ale,
  input logic       rdN,
  input logic       wrN,
  input logic [2:0] statusN,
  input logic       denN,
  input logic       ctrlOe,
  input logic       hlda
);
  assert_ale_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  assert_wait_keeps_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !srdy && !ardySync && !csAutoRdy) |=> !rdN);

  assert_passive_at_finish_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> statusN == 3'b111);

  assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  assert_den_off_in_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> denN);

  assert_hold_floats_R10: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> (!adOe && !addrHiOe && !ctrlOe));

  assert_no_accept_in_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> !reqAccept);
endmodule

bind busCycleUnit busCycleUnit_chk u_chk (.*);

// File: tb/busCycleUnit_bench.sv
module busCycleUnit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 6000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqByte = 0, reqLock = 0;
  logic [2:0] reqKind = 0;
  logic [19:0] reqAddr = 0;
  logic [15:0] reqWrData = 0;
  logic [1:0] reqInit = 0;
  logic srdy = 0, ardySync = 0, csAutoRdy = 0, holdReq = 0;
  logic reqAccept, adOe, addrHiOe, ale, rdN, wrN, bheN, denN, dtR, ctrlOe, hlda;
  logic [15:0] adOut;
  logic [3:0] addrHi;
  logic [2:0] statusN;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busCycleUnit u_busCycleUnit (.*);

  // Behavioural reference: phase number 0 idle, 1..4 cycle phases, 5 hold
  int mPh = 0;
  bit mLock = 0;
  logic [2:0] mKind = 3'b111;
  logic [19:0] mAddr = 0;
  logic mByte = 0;
  logic [15:0] mData = 0;
  logic [1:0] mInit = 0;
  string mEntryTag = "R1";
  string mEndTag = "R2";

  task automatic loadModel(bit lockedHold, bit fromFinish);
    mKind = reqKind; mAddr = reqAddr; mByte = reqByte; mData = reqWrData;
    mInit = reqInit; mLock = reqLock; mPh = 1;
    mEntryTag = lockedHold ? "R11" : (fromFinish ? "R12" : "R1");
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mLock = 0;
    end else begin
      bit hb;
      hb = holdReq && !mLock;
      case (mPh)
        0: if (hb) mPh = 5;
           else if (reqValid) loadModel(holdReq, 0);
           else mLock = 0;
        1: mPh = 2;
        2: mPh = 3;
        3: begin
          if (srdy || ardySync) begin mPh = 4; mEndTag = "R2"; end
          else if (csAutoRdy) begin mPh = 4; mEndTag = "R3"; end
          else if (mKind[1:0] == 2'b11) begin mPh = 4; mEndTag = "R13"; end
        end
        4: if (hb) mPh = 5;
           else if (reqValid) loadModel(holdReq, 1);
           else mPh = 0;
        default: begin mLock = 0; if (!holdReq) mPh = 0; end
      endcase
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h time=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit isRd, isWr, quiet, lane0, laneB;
    logic eAdOe, eHiOe, eAle, eRd, eWr, eBhe, eDen, eDt, eCtrl, eHlda, eAcc;
    logic [15:0] eAd; logic [3:0] eHi; logic [2:0] eSt;
    isRd  = (mKind == 1) || (mKind == 4) || (mKind == 5);
    isWr  = (mKind == 2) || (mKind == 6);
    quiet = (mKind[1:0] == 2'b11);
    lane0 = (mInit == 2) ? 1'b1 : mAddr[0];
    laneB = (mInit == 2) ? 1'b1 : (mByte && !mAddr[0]);
    eAdOe = 0; eAd = 0; eHi = 0; eHiOe = 1; eAle = 0; eRd = 1; eWr = 1; eSt = 3'b111;
    eBhe = 1; eDen = 1; eDt = 1; eCtrl = 1; eHlda = 0;
    case (mPh)
      1: begin
        eAdOe = 1; eAd = {mAddr[15:1], lane0}; eHi = mAddr[19:16]; eAle = 1;
        eSt = mKind; eBhe = laneB; eDt = isWr;
      end
      2, 3, 4: begin
        eAdOe = isWr; eAd = mData; eHi = {mInit != 0, 3'b000};
        eDen = quiet; eBhe = laneB; eDt = isWr;
        if (mPh != 4) begin eRd = !isRd; eWr = !isWr; eSt = mKind; end
      end
      5: begin eHiOe = 0; eCtrl = 0; eHlda = 1; end
      default: ;
    endcase
    eAcc = (mPh == 0 || mPh == 4) && reqValid && !(holdReq && !mLock);
    chk(mPh == 1 ? mEntryTag : "R1", "ale", ale, eAle);
    chk("R12", "reqAccept", reqAccept, eAcc);
    chk(mPh == 4 ? mEndTag : "R4", "statusN", statusN, eSt);
    chk("R5", "bheN", bheN, eBhe);
    if (mPh == 1) chk("R5", "lane A0", adOut[0], lane0);
    chk("R6", "addrHi", addrHi, eHi);
    chk("R7", "adOe", adOe, eAdOe);
    if (eAdOe) chk("R7", "adOut", adOut, eAd);
    chk("R8", "rdN", rdN, eRd);
    chk("R8", "wrN", wrN, eWr);
    chk("R9", "denN", denN, eDen);
    chk("R9", "dtR", dtR, eDt);
    chk("R10", "hlda", hlda, eHlda);
    chk("R10", "ctrlOe", ctrlOe, eCtrl);
    chk("R10", "addrHiOe", addrHiOe, eHiOe);
  endtask

  task automatic driveRandom(int cyc);
    int epoch;
    epoch = (cyc / 500) % 4;
    reqValid  = ($urandom_range(0, 3) != 0);
    reqKind   = 3'($urandom_range(0, 7));
    reqAddr   = 20'($urandom);
    reqByte   = 1'($urandom_range(0, 1));
    reqWrData = 16'($urandom);
    reqInit   = 2'($urandom_range(0, 2));
    reqLock   = ($urandom_range(0, 2) == 0);
    srdy = 0; ardySync = 0; csAutoRdy = 0;
    case (epoch)
      0: begin srdy = 1; holdReq = 0; end
      1: begin srdy = ($urandom_range(0, 3) == 0); ardySync = ($urandom_range(0, 3) == 0);
               holdReq = ($urandom_range(0, 3) == 0); end
      2: begin csAutoRdy = ($urandom_range(0, 2) == 0); holdReq = ($urandom_range(0, 1) == 0); end
      default: begin ardySync = ($urandom_range(0, 7) == 0); csAutoRdy = ($urandom_range(0, 7) == 0);
               holdReq = ($urandom_range(0, 2) != 0); end
    endcase
  endtask

  initial begin
    // Reset state, outputs idle and passive (R4, R10)
    repeat (3) @(negedge clk);
    #1;
    chk("R4", "reset statusN", statusN, 3'b111);
    chk("R10", "reset hlda", hlda, 0);
    chk("R8", "reset rdN", rdN, 1);
    @(negedge clk);
    rstN = 1;
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      driveRandom(cyc);
      #1;
      compareAll();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule